// File: doc/BRIEF.md
# Register-Mapped SPI Word Master

This block is a bus-attached SPI master that moves one word per exchange. Software chooses a peripheral through a control register holding a select index and an enable bit. It picks an 8-bit or 16-bit word through one configuration bit. An exchange starts when software writes the outgoing word. While the exchange runs, the block clocks the word out on MOSI and captures the same number of bits from MISO. When it finishes, it sets a sticky ready flag and an interrupt cause bit. Software can then read the received word.

The serial clock is paced by a one-cycle tick from an external divider. Each tick advances the serial clock by half a period. Only mode 0 is provided: SCK idles low, the master launches data on the falling edge, and both sides sample on the rising edge. Within a byte the most significant bit goes first. In a 16-bit exchange the low byte of the word travels before the high byte.

Top module: `spi_word_master`

## Requirements
- R1: After reset all select lines are high, SCK and the interrupt output are low, and control (0x00), data-in (0x0C) and interrupt cause (0x10) all read 0.
- R2: The control register at 0x00 holds the select enable in bit 0 and the select index in bits 4:2. Select line n is low exactly when the enable bit is 1 and the index equals n. Every other line stays high.
- R3: A write to data-out (0x08) while idle starts an exchange in mode 0. SCK is low whenever no exchange runs. Each tick toggles SCK. MOSI changes only when SCK falls.
- R4: With configuration bit 5 (offset 0x04) clear, an exchange is 8 bits. It sends written bits 7:0, most significant bit first.
- R5: With configuration bit 5 set, an exchange is 16 bits. It sends written bits 7:0 first and then bits 15:8, each byte most significant bit first.
- R6: Data-in (0x0C) holds the last received word, zero-extended to 32 bits. The first received byte lands in bits 7:0. In 16-bit mode the second received byte lands in bits 15:8.
- R7: Control bit 1 (read-ready) goes to 1 when an exchange completes. It stays 1 until a write to data-out starts the next exchange, and that write clears it.
- R8: A write to data-out while an exchange is running is ignored. The running exchange's MOSI stream is unchanged.
- R9: Bit 0 of the cause register (0x10) is set when an exchange completes. Writing 1 to it clears it. Writing 0 to it has no effect.
- R10: The interrupt output equals cause bit 0 AND bit 0 of the mask register (0x14).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | Write enable qualifying bus_sel |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sck_tick | input | 1 | Half-period pacing tick from an external divider |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |
| spi_cs_n | output | NCS | Active-low select lines |
| irq | output | 1 | Read-ready interrupt |

## Verification
The exchange is tried with an 8-bit word whose high bits are also set, to show that the unused byte neither goes out nor comes back. It is also tried with a 16-bit word of distinct bytes, which separates the order of the bytes from the order of the bits within each byte. A peripheral model returns its own distinct pattern, so a loopback or a byte swap in the receive path shows up. A second data-out write in the middle of an exchange tells ignoring the write apart from restarting or corrupting the exchange. Select decoding, the interrupt and SCK idling are compared against the model on every clock.

// File: rtl/spi_wm_pkg.sv
// Shared offsets and field positions for the SPI word master.
// Assumes a byte-addressed register space with 32-bit registers.
package spi_wm_pkg;
    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_CFG   = 8'h04;
    localparam logic [7:0] OFF_DOUT  = 8'h08;
    localparam logic [7:0] OFF_DIN   = 8'h0C;
    localparam logic [7:0] OFF_CAUSE = 8'h10;
    localparam logic [7:0] OFF_MASK  = 8'h14;
    localparam int CTRL_IDX_LSB = 2;
    localparam int CFG_WIDE_BIT = 5;
endpackage

// File: rtl/spi_wm_csdec.sv
// Select decoder: turns an index plus an enable into active-low select lines.
// Assumes the index is stable between register writes.
module spi_wm_csdec #(
    parameter int NCS = 8,
    localparam int IDX_W = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [NCS-1:0]   cs_n
);
    // One comparator per select line.
    for (genvar i = 0; i < NCS; i++) begin : g_line
        assign cs_n[i] = !(en && (idx == IDX_W'(i)));
    end

    p_cs_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);
    p_cs_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (&cs_n));
endmodule

// File: rtl/spi_wm_shifter.sv
// Mode-0 shift engine: one tick per SCK half period. MOSI is launched on the
// falling edge and MISO is sampled on the rising edge. In wide mode the
// low byte goes first, and each byte is sent most significant bit first.
// Assumes start is ignored by design while busy.
module spi_wm_shifter #(
    parameter int WORD_W = 16,
    localparam int BYTE_W = WORD_W / 2,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] tx_sh, rx_sh;
    logic [CNT_W-1:0]  bit_cnt;
    logic              wide_q, last_bit;

    // Final bit index depends on the width latched at start.
    assign last_bit = bit_cnt == (wide_q ? CNT_W'(WORD_W-1) : CNT_W'(BYTE_W-1));
    assign done     = busy && tick && sclk && last_bit;
    assign mosi     = tx_sh[WORD_W-1];
    // Reorder the captured stream so the first byte lands in the low byte.
    assign rx_word  = wide_q ? {rx_sh[BYTE_W-1:0], rx_sh[WORD_W-1:BYTE_W]}
                             : {{BYTE_W{1'b0}}, rx_sh[BYTE_W-1:0]};

    // Sequence the exchange: load, then alternate rise/sample and fall/shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; sclk <= 1'b0; wide_q <= 1'b0;
            tx_sh <= '0; rx_sh <= '0; bit_cnt <= '0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            sclk    <= 1'b0;
            wide_q  <= wide;
            tx_sh   <= wide ? {tx_word[BYTE_W-1:0], tx_word[WORD_W-1:BYTE_W]}
                            : {tx_word[BYTE_W-1:0], {BYTE_W{1'b0}}};
            rx_sh   <= '0;
            bit_cnt <= '0;
        end else if (busy && tick) begin
            if (!sclk) begin
                sclk  <= 1'b1;
                rx_sh <= {rx_sh[WORD_W-2:0], miso};
            end else begin
                sclk  <= 1'b0;
                tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                if (last_bit) busy <= 1'b0;
                else          bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);
    p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spi_wm_regs.sv
// Register file: control, configuration, data-out (start), data-in, interrupt
// cause (write-one-to-clear) and mask. Reads are combinational on bus_addr.
// Assumes a write is one bus_sel cycle with bus_we high.
module spi_wm_regs
    import spi_wm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NCS = 8,
    parameter int WORD_W = 16,
    localparam int IDX_W = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [WORD_W-1:0] rx_word,
    output logic              start,
    output logic              wide,
    output logic              cs_en,
    output logic [IDX_W-1:0]  cs_idx,
    output logic              irq
);
    logic              wr, ready, cause, mask;
    logic [WORD_W-1:0] rx_q;
    wire               unused_hi = ^bus_wdata[31:WORD_W];

    assign wr    = bus_sel && bus_we;
    assign start = wr && (bus_addr == ADDR_W'(OFF_DOUT)) && !busy;
    assign irq   = cause && mask;

    // Configuration-type registers written directly from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_en <= 1'b0; cs_idx <= '0; wide <= 1'b0; mask <= 1'b0;
        end else if (wr) begin
            if (bus_addr == ADDR_W'(OFF_CTRL)) begin
                cs_en  <= bus_wdata[0];
                cs_idx <= bus_wdata[CTRL_IDX_LSB +: IDX_W];
            end
            if (bus_addr == ADDR_W'(OFF_CFG))  wide <= bus_wdata[CFG_WIDE_BIT];
            if (bus_addr == ADDR_W'(OFF_MASK)) mask <= bus_wdata[0];
        end
    end

    // Completion state: ready flag, cause bit and captured word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0; cause <= 1'b0; rx_q <= '0;
        end else begin
            if (done) begin
                ready <= 1'b1;
                rx_q  <= rx_word;
            end else if (start) begin
                ready <= 1'b0;
            end
            if (done) cause <= 1'b1;
            else if (wr && bus_addr == ADDR_W'(OFF_CAUSE) && bus_wdata[0]) cause <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_CTRL): begin
                bus_rdata[0] = cs_en;
                bus_rdata[1] = ready;
                bus_rdata[CTRL_IDX_LSB +: IDX_W] = cs_idx;
            end
            ADDR_W'(OFF_CFG):   bus_rdata[CFG_WIDE_BIT] = wide;
            ADDR_W'(OFF_DIN):   bus_rdata[WORD_W-1:0] = rx_q;
            ADDR_W'(OFF_CAUSE): bus_rdata[0] = cause;
            ADDR_W'(OFF_MASK):  bus_rdata[0] = mask;
            default:            bus_rdata = '0;
        endcase
    end

    p_ready_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(OFF_DOUT) && !busy) |=> !ready);
    p_ready_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ready && cause));
    p_cause_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(OFF_CAUSE) && bus_wdata[0] && !done) |=> !irq);
endmodule

// File: rtl/spi_word_master.sv
// Top of the SPI word master: register file, mode-0 shift engine and select
// decoder. Assumes sck_tick is a one-cycle pulse from an external divider.
module spi_word_master
    import spi_wm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NCS = 8,
    parameter int WORD_W = 16,
    localparam int IDX_W = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              sck_tick,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NCS-1:0]    spi_cs_n,
    output logic              irq
);
    logic              start, wide, busy, done, cs_en;
    logic [IDX_W-1:0]  cs_idx;
    logic [WORD_W-1:0] rx_word;

    spi_wm_regs #(.ADDR_W(ADDR_W), .NCS(NCS), .WORD_W(WORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .rx_word(rx_word), .start(start),
        .wide(wide), .cs_en(cs_en), .cs_idx(cs_idx), .irq(irq)
    );

    spi_wm_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
        .tx_word(bus_wdata[WORD_W-1:0]), .tick(sck_tick), .miso(spi_miso),
        .busy(busy), .done(done), .sclk(spi_sclk), .mosi(spi_mosi),
        .rx_word(rx_word)
    );

    spi_wm_csdec #(.NCS(NCS)) u_cs (
        .clk(clk), .rst_n(rst_n), .en(cs_en), .idx(cs_idx), .cs_n(spi_cs_n)
    );

    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && bus_sel && bus_we && bus_addr == ADDR_W'(OFF_DOUT)) |=> busy);
endmodule

// File: tb/tb_spi_word_master.sv
// Bench: behavioural peripheral and register model, compared every clock.
module tb_spi_word_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, we = 1'b0, tick = 1'b0, miso = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sclk, mosi, irq;
    logic [7:0]  cs_n;

    int checks = 0, fails = 0;
    bit m_en = 0, m_mask = 0, m_cause = 0, prev_sclk = 0;
    int m_idx = 0, exp_n = 0, rise_cnt = 0, tcnt = 0;
    bit mosi_q[$];
    bit slave_q[$];

    always #4 clk = ~clk;

    spi_word_master dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .sck_tick(tick), .spi_sclk(sclk),
        .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Divider stand-in: one tick every third clock.
    always @(negedge clk) begin
        tcnt <= (tcnt + 1) % 3;
        tick <= (tcnt == 2);
    end

    // Per-clock model: peripheral stepping, SCK idle, select lines, interrupt.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (sclk && !prev_sclk) begin
                mosi_q.push_back(mosi);
                rise_cnt++;
            end
            if (!sclk && prev_sclk) begin
                if (slave_q.size() > 0) miso = slave_q.pop_front();
                if (exp_n > 0 && rise_cnt == exp_n) begin
                    m_cause = 1;
                    exp_n = 0;
                end
            end
            if (exp_n == 0) chk(sclk == 1'b0, "R3 sclk idle", {31'b0, sclk}, 0);
            chk(cs_n == (m_en ? ~(8'b1 << m_idx) : 8'hFF), "R2 select lines",
                {24'b0, cs_n}, m_en ? {24'b0, ~(8'b1 << m_idx)} : 32'hFF);
            chk(irq == (m_cause && m_mask), "R10 irq", {31'b0, irq}, {31'b0, m_cause && m_mask});
        end
        prev_sclk = sclk;
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1; we = 1; addr = a; wdata = d;
        @(posedge clk);
        if (a == 8'h00) begin m_en = d[0]; m_idx = int'(d[4:2]); end
        if (a == 8'h14) m_mask = d[0];
        if (a == 8'h10 && d[0]) m_cause = 0;
        @(negedge clk);
        sel = 0; we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    // One exchange; optionally a second data-out write part way through.
    task automatic xfer(input bit wide, input logic [15:0] tx, input logic [15:0] sl,
                        input bit intrude, input string req);
        logic [31:0] d;
        bit exp_s[$];
        int n = wide ? 16 : 8;
        slave_q.delete();
        mosi_q.delete();
        for (int i = 7; i >= 0; i--) begin exp_s.push_back(tx[i]); slave_q.push_back(sl[i]); end
        if (wide)
            for (int i = 15; i >= 8; i--) begin exp_s.push_back(tx[i]); slave_q.push_back(sl[i]); end
        miso = slave_q.pop_front();
        rise_cnt = 0;
        exp_n = n;
        wr(8'h08, {16'hA5A5, tx});
        rd(8'h00, d);
        chk(d[1] == 1'b0, "R7 ready cleared by start", d, 0);
        if (intrude) begin
            repeat (12) @(negedge clk);
            wr(8'h08, {16'h0, ~tx});
        end
        for (int k = 0; k < 400 && d[1] == 1'b0; k++) rd(8'h00, d);
        chk(d[1] == 1'b1, "R7 ready after exchange", d, 32'h2);
        chk(mosi_q.size() == n, {req, " bit count"}, mosi_q.size(), n);
        for (int i = 0; i < n && i < mosi_q.size(); i++)
            chk(mosi_q[i] == exp_s[i], {req, " mosi bit"}, {31'b0, mosi_q[i]}, {31'b0, exp_s[i]});
        rd(8'h0C, d);
        chk(d == (wide ? {16'h0, sl} : {24'h0, sl[7:0]}), "R6 data-in", d,
            wide ? {16'h0, sl} : {24'h0, sl[7:0]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1 reset state
        rd(8'h00, d); chk(d == 0, "R1 control", d, 0);
        rd(8'h0C, d); chk(d == 0, "R1 data-in", d, 0);
        rd(8'h10, d); chk(d == 0, "R1 cause", d, 0);
        chk(cs_n == 8'hFF && sclk == 0 && irq == 0, "R1 outputs", {cs_n, sclk, irq}, {8'hFF, 2'b0});
        // R2 decoding
        wr(8'h00, 32'h0D); chk(cs_n == 8'hF7, "R2 index 3", cs_n, 8'hF7);
        wr(8'h00, 32'h1D); chk(cs_n == 8'h7F, "R2 index 7", cs_n, 8'h7F);
        wr(8'h00, 32'h14); chk(cs_n == 8'hFF, "R2 disabled", cs_n, 8'hFF);
        wr(8'h00, 32'h01);
        // R4 8-bit, mask off
        xfer(0, 16'h00A5, 16'h003C, 0, "R4 8-bit");
        rd(8'h10, d); chk(d == 1, "R9 cause set", d, 1);
        chk(irq == 0, "R10 masked", irq, 0);
        wr(8'h14, 1); chk(irq == 1, "R10 unmasked", irq, 1);
        wr(8'h10, 0); rd(8'h10, d); chk(d == 1, "R9 write 0 no effect", d, 1);
        wr(8'h10, 1); rd(8'h10, d); chk(d == 0, "R9 write 1 clears", d, 0);
        chk(irq == 0, "R10 after clear", irq, 0);
        // R5 16-bit ordering
        wr(8'h04, 32'h20);
        xfer(1, 16'h1234, 16'hBEEF, 0, "R5 16-bit");
        xfer(1, 16'h80F1, 16'h0C96, 0, "R5 16-bit b");
        // R4/R6 high byte ignored in 8-bit mode
        wr(8'h04, 32'h0);
        xfer(0, 16'hFF81, 16'hFFC3, 0, "R4 high byte unused");
        // R8 write while busy ignored
        xfer(0, 16'h0096, 16'h005A, 1, "R8 busy write");
        repeat (10) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule